// File: doc/BRIEF.md
# Counting-Ramp Sample Quantizer Controller

This block is the digital half of a single-slope quantizer. A free-running counter produces a step code that drives an external weighted-resistor ramp DAC. An analog comparator outside the block reports whether the held analog sample is still above the ramp. The block brings that comparator bit in through a synchronizer and strobes the current step code into a working register once per ramp step. It only strobes while the comparator reads high. When the ramp crosses the input, the strobes stop, so the working register keeps the last step that was still below the input.

At the end of every ramp, the working result is moved to the output register and a one-cycle completion pulse is raised. The working register then starts the next ramp from zero. A coarse mode holds the step code's least significant bit at zero. The ramp then covers the same span in 8 levels instead of 16.

Each step lasts four clocks. The comparator is observed one clock after the step code changes, and the strobe falls two synchronizer stages later. With the default widths a ramp takes 64 clocks, which gives a 20 kHz sample rate from a 1.28 MHz clock.

Top module: `ramp_quantizer`

## Requirements
- R1: While reset is held and in the first cycle after it, step_code, held_code and ramp_done are all 0.
- R2: step_code rises by one every 4 clocks, from 0 to 15, and then wraps to 0, so one ramp lasts 64 clocks.
- R3: ramp_done is high for exactly one clock per ramp, in the first clock of the ramp (step code 0), and is low for the 63 clocks between pulses.
- R4: held_code changes only in a clock where ramp_done is high and stays constant for the rest of the ramp.
- R5: With a comparator that is high while the input level exceeds the step code, held_code after a clean ramp equals the highest step code k with level > k. The comparator is sampled through two synchronizer flops, and the sample used is the one taken one clock after step k begins.
- R6: The working result is cleared at the start of every ramp. An input at or below the lowest step therefore yields held_code 0, even right after a ramp that gave a high code.
- R7: With mode_3bit high, bit 0 of step_code is 0 in every clock, giving 8 levels (0,2,…,14). held_code is then the largest even code below the input level.
- R8: An input above the top step yields the full-scale code: 15 in 4-bit mode and 14 in 3-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_above | input | 1 | Asynchronous comparator bit, high while the sample exceeds the ramp |
| mode_3bit | input | 1 | High selects 8-level operation (step code bit 0 forced low) |
| step_code | output | 4 | Code driven to the external ramp DAC |
| held_code | output | 4 | Quantized result of the last completed ramp |
| ramp_done | output | 1 | One-clock pulse when a new result is presented |

## Verification
The bench places each input level so that the comparator flips at a known step. A strobe aligned to the wrong phase would then read the previous step's comparator value, and every result would be off by one. It runs a level of zero right after a high level, so a working register that is never cleared would carry the old code forward. Levels above the top step expose any off-by-one at the wrap, where the final strobe and the ramp end fall in the same clock. Coarse mode is checked for an odd bit leaking into either code. A level change in the middle of a ramp must leave the output untouched until the next completion pulse, and a design that publishes early would show the half-built value.

// File: rtl/ramp_quant_pkg.sv
package ramp_quant_pkg;

    localparam int CODE_W      = 4;  // ramp step code width
    localparam int SUB_W       = 2;  // counter stages below the step code
    localparam int SYNC_STAGES = 2;  // comparator synchronizer depth
    localparam int SETTLE_CLKS = 1;  // clocks from step change to comparator sample

    // per-clock ramp timing events
    typedef struct packed {
        logic start;   // first clock of a ramp
        logic strobe;  // synchronized comparator reflects the current step
        logic last;    // counter full, final clock of the ramp
    } ramp_evt_t;

    function automatic logic [CODE_W-1:0] apply_mode(input logic [CODE_W-1:0] code,
                                                     input logic coarse);
        logic [CODE_W-1:0] r;
        r = code;
        if (coarse) r[0] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ramp_sequencer.sv
module ramp_sequencer
    import ramp_quant_pkg::*;
#(
    parameter int CODE_W       = 4,
    parameter int SUB_W        = 2,
    parameter int STROBE_PHASE = 3
) (
    input  logic              clk,
    input  logic              rst,
    output logic [CODE_W-1:0] step,
    output ramp_evt_t         evt
);
    localparam int CNT_W = CODE_W + SUB_W;

    logic [CNT_W-1:0] cnt;
    logic [SUB_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign step  = cnt[CNT_W-1:SUB_W];
    assign phase = cnt[SUB_W-1:0];

    always_comb begin
        evt.start  = (cnt == '0);
        evt.strobe = (phase == SUB_W'(STROBE_PHASE));
        evt.last   = &cnt;
    end

    // R2: after the final clock the ramp restarts at step zero
    p_ramp_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        evt.last |=> (step == '0) && evt.start);

    // R2: the step code holds between phase wraps
    p_step_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (phase != '0) |-> $stable(step));
endmodule

// File: rtl/code_capture.sv
module code_capture
    import ramp_quant_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_evt_t         evt,
    input  logic              cmp_s,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] result,
    output logic              done
);
    logic [CODE_W-1:0] work;
    logic              take;

    assign take = evt.strobe && cmp_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= evt.last;
            if (evt.last) begin
                result <= take ? code : work;
                work   <= '0;
            end else if (take) begin
                work <= code;
            end
        end
    end

    // R6: every ramp begins from a cleared working register
    p_work_clear_r6: assert property (@(posedge clk) disable iff (rst)
        evt.start |-> (work == '0));

    // R4: the published result moves only together with the completion pulse
    p_result_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    // R3: completion is a single-clock pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/ramp_quantizer.sv
module ramp_quantizer
    import ramp_quant_pkg::*;
#(
    parameter int CODE_W      = ramp_quant_pkg::CODE_W,
    parameter int SUB_W       = ramp_quant_pkg::SUB_W,
    parameter int SYNC_STAGES = ramp_quant_pkg::SYNC_STAGES,
    parameter int SETTLE_CLKS = ramp_quant_pkg::SETTLE_CLKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_above,
    input  logic              mode_3bit,
    output logic [CODE_W-1:0] step_code,
    output logic [CODE_W-1:0] held_code,
    output logic              ramp_done
);
    localparam int STROBE_PHASE = SYNC_STAGES + SETTLE_CLKS;

    logic [CODE_W-1:0] raw_step;
    ramp_evt_t         evt;
    logic              cmp_s;

    ramp_sequencer #(
        .CODE_W      (CODE_W),
        .SUB_W       (SUB_W),
        .STROBE_PHASE(STROBE_PHASE)
    ) u_seq (
        .clk (clk),
        .rst (rst),
        .step(raw_step),
        .evt (evt)
    );

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (cmp_above),
        .q  (cmp_s)
    );

    assign step_code = apply_mode(raw_step, mode_3bit);

    code_capture #(.CODE_W(CODE_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .cmp_s (cmp_s),
        .code  (step_code),
        .result(held_code),
        .done  (ramp_done)
    );

    initial begin
        assert (STROBE_PHASE < (1 << SUB_W))
            else $error("strobe phase does not fit in one ramp step");
        assert (SYNC_STAGES >= 2)
            else $error("synchronizer needs at least two stages");
    end

    // R7: coarse mode keeps the upper bits of the ramp and zeroes bit 0
    p_coarse_step_r7: assert property (@(posedge clk) disable iff (rst)
        mode_3bit |-> !step_code[0] && ((step_code >> 1) == (raw_step >> 1)));

    // R3: the completion pulse lands in the first clock of a ramp
    p_done_at_start_r3: assert property (@(posedge clk) disable iff (rst)
        ramp_done |-> evt.start);
endmodule

// File: tb/ramp_quantizer_tb.sv
module ramp_quantizer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_3bit = 1'b0;
    logic [3:0] step_code;
    logic [3:0] held_code;
    logic       ramp_done;
    logic       cmp_above;
    int         level = 0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    // comparator model: high while the analog level is above the ramp step
    assign cmp_above = (level > int'(step_code));

    ramp_quantizer u_dut (
        .clk      (clk),
        .rst      (rst),
        .cmp_above(cmp_above),
        .mode_3bit(mode_3bit),
        .step_code(step_code),
        .held_code(held_code),
        .ramp_done(ramp_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int lvl, input bit coarse);
        int e;
        if (lvl <= 0) return 0;
        e = lvl - 1;
        if (e > 15) e = 15;
        if (coarse) e = e & ~1;
        return e;
    endfunction

    task automatic wait_done();
        do @(negedge clk); while (!ramp_done);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(step_code == 0 && held_code == 0 && ramp_done == 0, "R1 in reset",
            {step_code, held_code, 3'b0, ramp_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(step_code == 0 && held_code == 0 && ramp_done == 0, "R1 after reset",
            {step_code, held_code, 3'b0, ramp_done}, 0);
    endtask

    task automatic t_ramp_walk();
        int bad = 0;
        mode_3bit = 1'b0;
        wait_done();
        for (int i = 0; i < 64; i++) begin
            if (int'(step_code) != i / 4) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 step sequence mismatches", bad, 0);
        chk(step_code == 0, "R2 wrap to zero", step_code, 0);
    endtask

    task automatic t_done_period();
        int gap = 0;
        wait_done();
        do begin @(negedge clk); gap++; end while (!ramp_done);
        chk(gap == 64, "R3 pulse period", gap, 64);
        chk(step_code == 0, "R3 pulse at ramp start", step_code, 0);
        @(negedge clk);
        chk(ramp_done == 0, "R3 pulse width", ramp_done, 0);
    endtask

    task automatic t_level(input int lvl, input bit coarse, input string req);
        int e;
        level = lvl;
        mode_3bit = coarse;
        wait_done();
        wait_done();
        e = exp_code(lvl, coarse);
        chk(int'(held_code) == e, req, held_code, e);
    endtask

    task automatic t_hold();
        int bad = 0;
        t_level(10, 1'b0, "R5 level 10");
        repeat (20) @(negedge clk);
        level = 3;
        repeat (40) begin
            if (held_code != 4'd9 || ramp_done) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R4 held stable mid-ramp", bad, 0);
    endtask

    task automatic t_coarse_lsb();
        int bad = 0;
        mode_3bit = 1'b1;
        wait_done();
        for (int i = 0; i < 64; i++) begin
            if (step_code[0]) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R7 step bit0 in coarse mode", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ramp_walk();
        t_done_period();
        t_level(5, 1'b0, "R5 level 5");
        t_level(9, 1'b0, "R5 level 9");
        t_level(12, 1'b0, "R5 level 12");
        t_level(0, 1'b0, "R6 level 0 after high");
        t_level(1, 1'b0, "R6 level at lowest step");
        t_level(16, 1'b0, "R8 level 16");
        t_level(20, 1'b0, "R8 level 20");
        t_hold();
        t_coarse_lsb();
        t_level(7, 1'b1, "R7 coarse level 7");
        t_level(6, 1'b1, "R7 coarse level 6");
        t_level(20, 1'b1, "R8 coarse full scale");
        t_level(0, 1'b1, "R6 coarse level 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule